// File: doc/BRIEF.md
# SEC-DED Memory Word Guard with First-Error Capture

This block adds 8 check bits to each 64-bit memory word and checks them again when the word comes back. On the write side each strobed 64-bit word is returned as a 72-bit code word with its check byte attached. On the read side a 72-bit code word is checked and a syndrome is formed. A single flipped bit is repaired. A two-bit upset is reported as uncorrectable. The block has two independent read-side channels: one for words read from memory and one for data words arriving from the system bus.

Each channel keeps its own two-entry capture log. Once both entries of a log hold an error, that log ignores further errors until it is cleared. An entry records whether the error was correctable, the syndrome, the chunk index and the effective address that came with the word. A single enable input gates check-bit generation, checking and logging together. Software reads the logs through a select and index pair.

Top module: `ecc_guard`

## Requirements
- R1: One cycle after `wr_valid`, `wr_out_valid` is high and `wr_out_code` carries the data in bits [63:0] and the check byte in bits [71:64]. The check byte is the XOR of the columns of all set data bits. Column i is the i-th 8-bit value in ascending numeric order among the values with three bits set, for i below 56. For i from 56 to 63 it is the (i-56)-th value in ascending order among the values with five bits set.
- R2: On either read channel, the syndrome is the check byte recomputed from bits [63:0] XOR the received bits [71:64]. A zero syndrome returns the data unchanged one cycle after the strobe, with neither error flag set.
- R3: When the syndrome equals the column of data bit k, that bit is inverted in the returned data. The single-bit flag is set and the multi-bit flag is clear.
- R4: When the syndrome has exactly one bit set (an upset in a check bit), the data is returned unchanged and the single-bit flag is set.
- R5: Any other nonzero syndrome, which includes every two-bit upset, sets the multi-bit flag and leaves the single-bit flag clear. The data is returned as received. The two flags are never high together.
- R6: While `ecc_en` is low at the strobe, the written check byte is zero. Read data passes through raw, both flags stay low, and nothing is logged.
- R7: A flagged error on the memory channel is stored in the first empty entry of the memory log, entry 0 before entry 1. The entry holds the type (`log_multi` 1 for multi-bit), the syndrome, the chunk and the address. It is readable two cycles after the read strobe. Both logs are empty after reset.
- R8: While both entries of a log are valid, further errors on that channel are dropped and the stored entries do not change.
- R9: Errors on the bus channel go only to the bus log, and memory-channel errors go only to the memory log.
- R10: A clear pulse empties both entries of its own log one cycle later and leaves the other log untouched. A capture due in the same cycle as the clear is dropped.
- R11: `log_sel` picks the log (0 memory, 1 bus) and `log_idx` picks the entry. The readout outputs follow these selects combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | Enables generation, checking and logging |
| wr_valid | input | 1 | Write word strobe |
| wr_data | input | 64 | Write data word |
| wr_out_valid | output | 1 | Encoded word valid |
| wr_out_code | output | 72 | Check byte in [71:64], data in [63:0] |
| rd_valid | input | 1 | Memory read word strobe |
| rd_code | input | 72 | Memory code word |
| rd_chunk | input | 2 | Chunk index of the memory word |
| rd_addr | input | 32 | Effective address of the memory word |
| rd_out_valid | output | 1 | Memory result valid |
| rd_out_data | output | 64 | Corrected memory data |
| rd_out_sbe | output | 1 | Memory single-bit error |
| rd_out_mbe | output | 1 | Memory uncorrectable error |
| bus_valid | input | 1 | Bus data word strobe |
| bus_code | input | 72 | Bus code word |
| bus_chunk | input | 2 | Chunk index of the bus word |
| bus_addr | input | 32 | Address of the bus word |
| bus_out_valid | output | 1 | Bus result valid |
| bus_out_data | output | 64 | Corrected bus data |
| bus_out_sbe | output | 1 | Bus single-bit error |
| bus_out_mbe | output | 1 | Bus uncorrectable error |
| mem_log_clr | input | 1 | Empties the memory log |
| bus_log_clr | input | 1 | Empties the bus log |
| log_sel | input | 1 | Log select (0 memory, 1 bus) |
| log_idx | input | 1 | Entry select |
| log_valid | output | 1 | Selected entry holds an error |
| log_multi | output | 1 | Selected entry is multi-bit |
| log_syn | output | 8 | Selected entry syndrome |
| log_chunk | output | 2 | Selected entry chunk index |
| log_addr | output | 32 | Selected entry address |

## Verification
The encoded write word and both read results are registered once. Each is therefore due one clock after its strobe. A log entry is written from the registered read result, so it appears one cycle later than that result, two cycles after the strobe. The log readout is combinational, and a clear takes effect at the next edge. The bench drives every input on the falling edge and samples results on a later falling edge, at exactly these counts. After moving the log selects it waits a short delay before reading.

// File: rtl/ecc_pkg.sv
`timescale 1ns/1ps
package ecc_pkg;
  localparam int DATA_W    = 64;
  localparam int CHK_W     = 8;
  localparam int CODE_W    = DATA_W + CHK_W;
  localparam int CHUNK_W   = 2;
  localparam int ADDR_W    = 32;
  localparam int LOG_DEPTH = 2;
  localparam int LOG_IDX_W = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1;
  localparam int N_CH      = 2;

  // Odd-weight columns: all weight-3 values ascending, then weight-5 ascending.
  function automatic logic [DATA_W*CHK_W-1:0] build_cols();
    logic [DATA_W*CHK_W-1:0] t;
    int n;
    t = '0;
    n = 0;
    for (int w = 3; w <= 5; w += 2) begin
      for (int v = 1; v < (1 << CHK_W); v++) begin
        if (($countones(v[CHK_W-1:0]) == w) && (n < DATA_W)) begin
          t[n*CHK_W +: CHK_W] = v[CHK_W-1:0];
          n++;
        end
      end
    end
    return t;
  endfunction

  localparam logic [DATA_W*CHK_W-1:0] COL_TAB = build_cols();

  function automatic logic [CHK_W-1:0] col_of(input int idx);
    return COL_TAB[idx*CHK_W +: CHK_W];
  endfunction

  function automatic logic [CHK_W-1:0] check_bits(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    c = '0;
    for (int i = 0; i < DATA_W; i++)
      if (d[i]) c = c ^ col_of(i);
    return c;
  endfunction

  typedef struct packed {
    logic               multi;
    logic [CHK_W-1:0]   syn;
    logic [CHUNK_W-1:0] chunk;
    logic [ADDR_W-1:0]  addr;
  } err_rec_t;
endpackage

// File: rtl/ecc_encoder.sv
`timescale 1ns/1ps
module ecc_encoder
  import ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code
);
  logic [CHK_W-1:0] gen_chk;

  always_comb gen_chk = en ? check_bits(in_data) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_code <= {gen_chk, in_data};
    end
  end

  AST_WR_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid && (out_code[DATA_W-1:0] == $past(in_data))); // R1
  AST_WR_DIS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !en) |=> (out_code[CODE_W-1:DATA_W] == '0)); // R6
endmodule

// File: rtl/ecc_checker.sv
`timescale 1ns/1ps
module ecc_checker
  import ecc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               in_valid,
  input  logic [CODE_W-1:0]  in_code,
  input  logic [CHUNK_W-1:0] in_chunk,
  input  logic [ADDR_W-1:0]  in_addr,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_sbe,
  output logic               out_mbe,
  output err_rec_t           out_rec
);
  logic [DATA_W-1:0] data_in;
  logic [CHK_W-1:0]  chk_in;
  logic [CHK_W-1:0]  syn;
  logic [DATA_W-1:0] data_hit;
  logic              chk_hit;
  logic              single_c;
  logic              multi_c;
  logic [DATA_W-1:0] fixed;

  always_comb begin
    data_in = in_code[DATA_W-1:0];
    chk_in  = in_code[CODE_W-1:DATA_W];
    syn     = check_bits(data_in) ^ chk_in;
    for (int i = 0; i < DATA_W; i++)
      data_hit[i] = (syn == col_of(i));
    chk_hit  = ($countones(syn) == 1);
    single_c = en && ((|data_hit) || chk_hit);
    multi_c  = en && (syn != '0) && !((|data_hit) || chk_hit);
    fixed    = en ? (data_in ^ data_hit) : data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sbe   <= 1'b0;
      out_mbe   <= 1'b0;
      out_rec   <= '0;
    end else begin
      out_valid <= in_valid;
      out_sbe   <= in_valid && single_c;
      out_mbe   <= in_valid && multi_c;
      if (in_valid) begin
        out_data      <= fixed;
        out_rec.multi <= multi_c;
        out_rec.syn   <= syn;
        out_rec.chunk <= in_chunk;
        out_rec.addr  <= in_addr;
      end
    end
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_sbe && out_mbe)); // R5
  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sbe || out_mbe) |-> out_valid); // R2
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !en) |=> (!out_sbe && !out_mbe && out_data == $past(in_code[DATA_W-1:0]))); // R6
endmodule

// File: rtl/ecc_err_log.sv
`timescale 1ns/1ps
module ecc_err_log
  import ecc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 cap_valid,
  input  logic                 cap_sbe,
  input  logic                 cap_mbe,
  input  err_rec_t             cap_rec,
  input  logic [LOG_IDX_W-1:0] rd_idx,
  output logic                 rd_valid,
  output err_rec_t             rd_rec
);
  logic [LOG_DEPTH-1:0]  valid;
  err_rec_t              ent [LOG_DEPTH];
  logic                  any_free;
  logic [LOG_IDX_W-1:0]  free_idx;
  logic                  capture;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int k = LOG_DEPTH-1; k >= 0; k--) begin
      if (!valid[k]) begin
        any_free = 1'b1;
        free_idx = LOG_IDX_W'(k);
      end
    end
    capture = cap_valid && (cap_sbe || cap_mbe) && !clr && any_free;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0;
      for (int k = 0; k < LOG_DEPTH; k++) ent[k] <= '0;
    end else if (clr) begin
      valid <= '0;
    end else if (capture) begin
      valid[free_idx] <= 1'b1;
      ent[free_idx]   <= cap_rec;
    end
  end

  always_comb begin
    rd_valid = valid[rd_idx];
    rd_rec   = ent[rd_idx];
  end

  AST_LOG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (valid == '0)); // R10

  for (genvar k = 0; k < LOG_DEPTH; k++) begin : g_chk
    AST_LOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid[k] && !clr) |=> (valid[k] && $stable(ent[k]))); // R8
    if (k > 0) begin : g_ord
      AST_LOG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        valid[k] |-> valid[k-1]); // R7
    end
  end
endmodule

// File: rtl/ecc_guard.sv
`timescale 1ns/1ps
module ecc_guard
  import ecc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ecc_en,
  input  logic                 wr_valid,
  input  logic [DATA_W-1:0]    wr_data,
  output logic                 wr_out_valid,
  output logic [CODE_W-1:0]    wr_out_code,
  input  logic                 rd_valid,
  input  logic [CODE_W-1:0]    rd_code,
  input  logic [CHUNK_W-1:0]   rd_chunk,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic                 rd_out_valid,
  output logic [DATA_W-1:0]    rd_out_data,
  output logic                 rd_out_sbe,
  output logic                 rd_out_mbe,
  input  logic                 bus_valid,
  input  logic [CODE_W-1:0]    bus_code,
  input  logic [CHUNK_W-1:0]   bus_chunk,
  input  logic [ADDR_W-1:0]    bus_addr,
  output logic                 bus_out_valid,
  output logic [DATA_W-1:0]    bus_out_data,
  output logic                 bus_out_sbe,
  output logic                 bus_out_mbe,
  input  logic                 mem_log_clr,
  input  logic                 bus_log_clr,
  input  logic                 log_sel,
  input  logic [LOG_IDX_W-1:0] log_idx,
  output logic                 log_valid,
  output logic                 log_multi,
  output logic [CHK_W-1:0]     log_syn,
  output logic [CHUNK_W-1:0]   log_chunk,
  output logic [ADDR_W-1:0]    log_addr
);
  localparam int CH_MEM = 0;
  localparam int CH_BUS = 1;

  logic               ch_in_valid [N_CH];
  logic [CODE_W-1:0]  ch_in_code  [N_CH];
  logic [CHUNK_W-1:0] ch_in_chunk [N_CH];
  logic [ADDR_W-1:0]  ch_in_addr  [N_CH];
  logic               ch_clr      [N_CH];
  logic               ch_valid    [N_CH];
  logic [DATA_W-1:0]  ch_data     [N_CH];
  logic               ch_sbe      [N_CH];
  logic               ch_mbe      [N_CH];
  err_rec_t           ch_rec      [N_CH];
  logic               lg_valid    [N_CH];
  err_rec_t           lg_rec      [N_CH];
  err_rec_t           sel_rec;

  ecc_encoder u_enc (
    .clk(clk), .rst_n(rst_n), .en(ecc_en),
    .in_valid(wr_valid), .in_data(wr_data),
    .out_valid(wr_out_valid), .out_code(wr_out_code)
  );

  always_comb begin
    ch_in_valid[CH_MEM] = rd_valid;
    ch_in_code [CH_MEM] = rd_code;
    ch_in_chunk[CH_MEM] = rd_chunk;
    ch_in_addr [CH_MEM] = rd_addr;
    ch_clr     [CH_MEM] = mem_log_clr;
    ch_in_valid[CH_BUS] = bus_valid;
    ch_in_code [CH_BUS] = bus_code;
    ch_in_chunk[CH_BUS] = bus_chunk;
    ch_in_addr [CH_BUS] = bus_addr;
    ch_clr     [CH_BUS] = bus_log_clr;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    ecc_checker u_chk (
      .clk(clk), .rst_n(rst_n), .en(ecc_en),
      .in_valid(ch_in_valid[c]), .in_code(ch_in_code[c]),
      .in_chunk(ch_in_chunk[c]), .in_addr(ch_in_addr[c]),
      .out_valid(ch_valid[c]), .out_data(ch_data[c]),
      .out_sbe(ch_sbe[c]), .out_mbe(ch_mbe[c]), .out_rec(ch_rec[c])
    );
    ecc_err_log u_log (
      .clk(clk), .rst_n(rst_n), .clr(ch_clr[c]),
      .cap_valid(ch_valid[c]), .cap_sbe(ch_sbe[c]), .cap_mbe(ch_mbe[c]),
      .cap_rec(ch_rec[c]), .rd_idx(log_idx),
      .rd_valid(lg_valid[c]), .rd_rec(lg_rec[c])
    );
  end

  always_comb begin
    rd_out_valid  = ch_valid[CH_MEM];
    rd_out_data   = ch_data [CH_MEM];
    rd_out_sbe    = ch_sbe  [CH_MEM];
    rd_out_mbe    = ch_mbe  [CH_MEM];
    bus_out_valid = ch_valid[CH_BUS];
    bus_out_data  = ch_data [CH_BUS];
    bus_out_sbe   = ch_sbe  [CH_BUS];
    bus_out_mbe   = ch_mbe  [CH_BUS];
    log_valid     = log_sel ? lg_valid[CH_BUS] : lg_valid[CH_MEM];
    sel_rec       = log_sel ? lg_rec[CH_BUS]   : lg_rec[CH_MEM];
    log_multi     = sel_rec.multi;
    log_syn       = sel_rec.syn;
    log_chunk     = sel_rec.chunk;
    log_addr      = sel_rec.addr;
  end

  AST_BUS_KEEPS_OFF_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid == 1'b0) |=> (rd_out_valid == 1'b0)); // R9
endmodule

// File: tb/ecc_guard_test.sv
`timescale 1ns/1ps
module ecc_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ecc_en = 1'b0;
  logic        wr_valid = 1'b0;
  logic [63:0] wr_data = '0;
  logic        wr_out_valid;
  logic [71:0] wr_out_code;
  logic        rd_valid = 1'b0;
  logic [71:0] rd_code = '0;
  logic [1:0]  rd_chunk = '0;
  logic [31:0] rd_addr = '0;
  logic        rd_out_valid;
  logic [63:0] rd_out_data;
  logic        rd_out_sbe, rd_out_mbe;
  logic        bus_valid = 1'b0;
  logic [71:0] bus_code = '0;
  logic [1:0]  bus_chunk = '0;
  logic [31:0] bus_addr = '0;
  logic        bus_out_valid;
  logic [63:0] bus_out_data;
  logic        bus_out_sbe, bus_out_mbe;
  logic        mem_log_clr = 1'b0;
  logic        bus_log_clr = 1'b0;
  logic        log_sel = 1'b0;
  logic [0:0]  log_idx = '0;
  logic        log_valid, log_multi;
  logic [7:0]  log_syn;
  logic [1:0]  log_chunk;
  logic [31:0] log_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] tb_col [64];

  always #2.5 clk = ~clk;

  ecc_guard uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int pop8(input logic [7:0] v);
    int n = 0;
    for (int b = 0; b < 8; b++) n += int'(v[b]);
    return n;
  endfunction

  function automatic logic [7:0] tb_gen(input logic [63:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < 64; i++) if (d[i]) c ^= tb_col[i];
    return c;
  endfunction

  task automatic model_read(input logic [71:0] c, input logic en,
                            output logic [63:0] d, output logic s, output logic m,
                            output logic [7:0] sy);
    d = c[63:0]; s = 0; m = 0;
    sy = tb_gen(c[63:0]) ^ c[71:64];
    if (en && sy != 0) begin
      if (pop8(sy) == 1) s = 1;
      else begin
        for (int k = 0; k < 64; k++)
          if (!s && sy == tb_col[k]) begin s = 1; d[k] = ~d[k]; end
        if (!s) m = 1;
      end
    end
  endtask

  task automatic do_write(input logic [63:0] d, output logic v, output logic [71:0] code);
    @(negedge clk); wr_valid = 1; wr_data = d;
    @(negedge clk); wr_valid = 0; v = wr_out_valid; code = wr_out_code;
  endtask

  task automatic do_read(input bit bus, input logic [71:0] c, input logic [1:0] ch,
                         input logic [31:0] ad, output logic v, output logic [63:0] d,
                         output logic s, output logic m);
    @(negedge clk);
    if (bus) begin bus_valid = 1; bus_code = c; bus_chunk = ch; bus_addr = ad; end
    else begin rd_valid = 1; rd_code = c; rd_chunk = ch; rd_addr = ad; end
    @(negedge clk);
    rd_valid = 0; bus_valid = 0;
    if (bus) begin v = bus_out_valid; d = bus_out_data; s = bus_out_sbe; m = bus_out_mbe; end
    else begin v = rd_out_valid; d = rd_out_data; s = rd_out_sbe; m = rd_out_mbe; end
  endtask

  task automatic check_read(input bit bus, input logic [71:0] c, input string req);
    logic v, s, m, es, em; logic [63:0] d, ed; logic [7:0] sy;
    model_read(c, ecc_en, ed, es, em, sy);
    do_read(bus, c, 2'd0, 32'd0, v, d, s, m);
    check(v == 1, req, "result valid", 72'(v), 72'd1);
    check(d == ed, req, "data", 72'(d), 72'(ed));
    check({s, m} == {es, em}, req, "flags sbe,mbe", 72'({s, m}), 72'({es, em}));
  endtask

  task automatic check_entry(input logic sel, input logic idx, input logic ev,
                             input logic em, input logic [7:0] esy, input logic [1:0] ech,
                             input logic [31:0] ead, input string req);
    log_sel = sel; log_idx = idx; #1;
    check(log_valid == ev, req, "entry valid", 72'(log_valid), 72'(ev));
    if (ev) begin
      check(log_multi == em, req, "entry type", 72'(log_multi), 72'(em));
      check(log_syn == esy, req, "entry syndrome", 72'(log_syn), 72'(esy));
      check({log_chunk, log_addr} == {ech, ead}, req, "entry chunk,addr",
            72'({log_chunk, log_addr}), 72'({ech, ead}));
    end
  endtask

  task automatic pulse_clr(input bit mem, input bit bus);
    @(negedge clk); mem_log_clr = mem; bus_log_clr = bus;
    @(negedge clk); mem_log_clr = 0; bus_log_clr = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic v, s, m, es, em; logic [63:0] d, ed; logic [71:0] code, good;
    logic [7:0] sy, sy1, sy2; int n;
    n = 0;
    for (int w = 3; w <= 5; w += 2)
      for (int x = 1; x < 256; x++)
        if (pop8(8'(x)) == w && n < 64) begin tb_col[n] = 8'(x); n++; end
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    check(rd_out_valid == 0 && wr_out_valid == 0, "R2", "outputs idle in reset", 72'({rd_out_valid, wr_out_valid}), 72'd0);
    @(negedge clk); rst_n = 1;
    check_entry(0, 0, 0, 0, 0, 0, 0, "R7 reset mem log");
    check_entry(1, 1, 0, 0, 0, 0, 0, "R7 reset bus log");
    ecc_en = 1;

    // R1 write path, directed and random
    do_write(64'd0, v, code);
    check(v == 1 && code == 72'd0, "R1", "zero word", code, 72'd0);
    do_write('1, v, code);
    check(code == {tb_gen('1), 64'hFFFF_FFFF_FFFF_FFFF}, "R1", "ones word", code, {tb_gen('1), 64'hFFFF_FFFF_FFFF_FFFF});
    for (int t = 0; t < 30; t++) begin
      d = {$urandom(), $urandom()};
      do_write(d, v, code);
      check(v == 1 && code == {tb_gen(d), d}, "R1", "random encode", code, {tb_gen(d), d});
    end

    // R2..R5 random read injections on both channels
    for (int t = 0; t < 80; t++) begin
      int kind, p, q;
      d = {$urandom(), $urandom()};
      good = {tb_gen(d), d};
      kind = $urandom_range(0, 3);
      p = $urandom_range(0, 71);
      q = (p + $urandom_range(1, 71)) % 72;
      code = good;
      if (kind == 1 || kind == 2) code[p] = ~code[p];
      if (kind == 2) code[q] = ~code[q];
      if (kind == 3) code[64 + (p % 8)] = ~code[64 + (p % 8)];
      check_read(t[0], code, kind == 0 ? "R2" : kind == 2 ? "R5" : kind == 3 ? "R4" : "R3");
    end

    // directed corners
    d = 64'h0123_4567_89AB_CDEF; good = {tb_gen(d), d};
    check_read(0, good ^ 72'd1, "R3 data bit 0");
    check_read(0, good ^ (72'd1 << 63), "R3 data bit 63");
    check_read(0, good ^ (72'd1 << 64), "R4 check bit 0");
    check_read(0, good ^ (72'd1 << 71), "R4 check bit 7");
    check_read(1, good ^ (72'd1 << 5) ^ (72'd1 << 70), "R5 data+check pair");
    check_read(1, good ^ 72'd3, "R5 adjacent pair");
    do_read(0, good ^ (72'd1 << 17), 0, 0, v, d, s, m);
    check(d == good[63:0] && s && !m, "R3", "corrected value", 72'(d), 72'(good[63:0]));

    // log capture
    pulse_clr(1, 1);
    check_entry(0, 0, 0, 0, 0, 0, 0, "R10 mem cleared");
    check_entry(1, 0, 0, 0, 0, 0, 0, "R10 bus cleared");
    code = good ^ (72'd1 << 9);
    sy1 = tb_gen(code[63:0]) ^ code[71:64];
    do_read(0, code, 2'd1, 32'hA000_0010, v, d, s, m);
    @(negedge clk);
    check_entry(0, 0, 1, 0, sy1, 2'd1, 32'hA000_0010, "R7 R11 first entry");
    check_entry(0, 1, 0, 0, 0, 0, 0, "R7 second still empty");
    code = good ^ (72'd1 << 2) ^ (72'd1 << 40);
    sy2 = tb_gen(code[63:0]) ^ code[71:64];
    do_read(0, code, 2'd3, 32'hB000_0020, v, d, s, m);
    @(negedge clk);
    check_entry(0, 1, 1, 1, sy2, 2'd3, 32'hB000_0020, "R7 second entry multi");
    code = good ^ (72'd1 << 66);
    do_read(0, code, 2'd2, 32'hC000_0030, v, d, s, m);
    @(negedge clk);
    check_entry(0, 0, 1, 0, sy1, 2'd1, 32'hA000_0010, "R8 entry0 kept");
    check_entry(0, 1, 1, 1, sy2, 2'd3, 32'hB000_0020, "R8 entry1 kept");
    check_entry(1, 0, 0, 0, 0, 0, 0, "R9 bus log untouched");

    // bus log
    code = good ^ (72'd1 << 33);
    sy = tb_gen(code[63:0]) ^ code[71:64];
    do_read(1, code, 2'd2, 32'hD000_0040, v, d, s, m);
    check(v && s && d == good[63:0], "R9", "bus corrected", 72'(d), 72'(good[63:0]));
    @(negedge clk);
    check_entry(1, 0, 1, 0, sy, 2'd2, 32'hD000_0040, "R9 R11 bus entry");
    check_entry(0, 0, 1, 0, sy1, 2'd1, 32'hA000_0010, "R9 mem log unchanged");

    // clear one log only
    pulse_clr(1, 0);
    check_entry(0, 0, 0, 0, 0, 0, 0, "R10 mem entry0 empty");
    check_entry(0, 1, 0, 0, 0, 0, 0, "R10 mem entry1 empty");
    check_entry(1, 0, 1, 0, sy, 2'd2, 32'hD000_0040, "R10 bus kept");

    // clear wins over a capture in the same cycle
    do_read(0, good ^ (72'd1 << 12), 2'd0, 32'h1, v, d, s, m);
    mem_log_clr = 1;
    @(negedge clk); mem_log_clr = 0;
    @(negedge clk);
    check_entry(0, 0, 0, 0, 0, 0, 0, "R10 capture dropped on clear");

    // disabled
    ecc_en = 0;
    d = 64'hDEAD_BEEF_0BAD_F00D;
    do_write(d, v, code);
    check(code == {8'd0, d}, "R6", "check bits zero when off", code, {8'd0, d});
    code = good ^ (72'd1 << 20) ^ (72'd1 << 30);
    do_read(0, code, 2'd1, 32'h2, v, ed, s, m);
    check(ed == code[63:0] && !s && !m, "R6", "raw pass, no flags", 72'({ed, s, m}), 72'({code[63:0], 2'b00}));
    @(negedge clk);
    check_entry(0, 0, 0, 0, 0, 0, 0, "R6 nothing logged");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule